// File: doc/BRIEF.md
# Dual-Control Add/Subtract/Logic ALU

A purely combinational arithmetic logic unit operating on two `WIDTH`-bit operands (32 by default). Two control inputs steer it. The operation bit selects the variant inside both internal units at once: with the bit low, the logic unit forms the bitwise OR and the arithmetic unit forms the sum. With the bit high, they form the bitwise AND and the difference. The path bit then picks which of the two unit outputs drives `result`.

The arithmetic unit is a ripple chain of one-bit full adders. The operation bit is XORed into every bit of operand B and also enters the chain as the least significant carry-in. Subtraction therefore evaluates A + ~B + 1. The block exports the carry out of the top stage and a signed-overflow flag. Both flags always describe the arithmetic unit for the current operation bit, whichever path reaches `result`.

Top module: `dual_ctl_alu`

## Requirements
- R1: With `path_sel`=0 and `op_mode`=0, `result` equals `opd_a | opd_b`.
- R2: With `path_sel`=0 and `op_mode`=1, `result` equals `opd_a & opd_b`.
- R3: With `path_sel`=1 and `op_mode`=0, `result` equals `(opd_a + opd_b) mod 2^WIDTH`.
- R4: With `path_sel`=1 and `op_mode`=1, `result` equals `(opd_a + ~opd_b + 1) mod 2^WIDTH`, so A − A gives zero.
- R5: `carry_out` is bit WIDTH of `opd_a + (opd_b XOR {WIDTH{op_mode}}) + op_mode`. For subtraction, 1 means no unsigned borrow (A ≥ B).
- R6: `ovf` equals the carry into the top stage XOR the carry out of it. Equivalently, it is 1 exactly when both adder inputs (A, and B after the XOR) share a sign and the sum's sign differs from it.
- R7: `carry_out` and `ovf` follow R5 and R6 for the current `op_mode` even while `path_sel`=0 selects the logic result.
- R8: The block holds no state. All outputs are a function of the present inputs only, with no clock or reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_a | input | WIDTH | First operand |
| opd_b | input | WIDTH | Second operand |
| op_mode | input | 1 | 0: OR / add, 1: AND / subtract |
| path_sel | input | 1 | 0: logic result, 1: arithmetic result |
| result | output | WIDTH | Selected unit output |
| carry_out | output | 1 | Carry out of the top adder stage |
| ovf | output | 1 | Signed overflow of the arithmetic unit |

## Verification
The hardest situation to create is a carry that ripples through every stage while signed overflow holds at the same time. The flag logic must then agree with the top stage's carry-in under both the add and the subtract inversion. Directed vectors reach this point in several ways. Adding 0x7FFFFFFF to 1 overflows positively. Subtracting 1 from 0x80000000 overflows negatively. Pairing all ones with 1 in both modes carries through all 32 stages. These directed cases are also replayed with the logic path selected, to check that the flags do not depend on `path_sel`. Pseudo-random operand pairs then exercise all four control combinations.

// File: rtl/dual_ctl_alu.sv
module dual_ctl_alu #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opd_a,
  input  logic [WIDTH-1:0] opd_b,
  input  logic             op_mode,
  input  logic             path_sel,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             ovf
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] logic_res;
  logic [WIDTH-1:0] arith_res;
  logic [WIDTH-1:0] b_eff;

  assign logic_res = op_mode ? (opd_a & opd_b) : (opd_a | opd_b);
  assign b_eff     = opd_b ^ {WIDTH{op_mode}};

  genvar i;
  for (i = 0; i < WIDTH; i++) begin : g_fa
    logic cin, s, co;
    if (i == 0) begin : g_lsb
      assign cin = op_mode;
    end else begin : g_mid
      assign cin = g_fa[i-1].co;
    end
    assign s  = opd_a[i] ^ b_eff[i] ^ cin;
    assign co = (opd_a[i] & b_eff[i]) | (cin & (opd_a[i] ^ b_eff[i]));
    assign arith_res[i] = s;
  end

  assign carry_out = g_fa[MSB].co;
  assign ovf       = g_fa[MSB].cin ^ g_fa[MSB].co;
  assign result    = path_sel ? arith_res : logic_res;

  logic [WIDTH:0] ref_sum;
  assign ref_sum = {1'b0, opd_a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, op_mode};

  always_comb begin
    if (!$isunknown({opd_a, opd_b, op_mode, path_sel})) begin
      if (!path_sel && !op_mode)
        a_r1_or: assert (result == (opd_a | opd_b));
      if (!path_sel && op_mode)
        a_r2_and: assert (result == (opd_a & opd_b));
      if (path_sel && !op_mode)
        a_r3_add: assert (result == opd_a + opd_b);
      if (path_sel && op_mode)
        a_r4_sub: assert (result == opd_a - opd_b);
      a_r5_carry: assert (carry_out == ref_sum[WIDTH]);
      a_r6_ovf: assert (ovf == ((opd_a[MSB] == b_eff[MSB]) && (ref_sum[MSB] != opd_a[MSB])));
    end
  end

endmodule

// File: tb/dual_ctl_alu_test.sv
module dual_ctl_alu_test;

  localparam int W = 32;

  typedef struct {
    logic [W-1:0] exp_res;
    logic         exp_c;
    logic         exp_v;
    string        tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic mode = 1'b0, sel = 1'b0;
  logic [W-1:0] res;
  logic c_o, v_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  item_t q[$];

  always #10 clk = ~clk;

  dual_ctl_alu #(.WIDTH(W)) uut (
    .opd_a(a), .opd_b(b), .op_mode(mode), .path_sel(sel),
    .result(res), .carry_out(c_o), .ovf(v_o)
  );

  function automatic item_t model(input logic [W-1:0] x, input logic [W-1:0] y,
                                  input logic m, input logic s, input string t);
    item_t it;
    logic [W:0] sum;
    logic [W-1:0] yy;
    yy  = m ? ~y : y;
    sum = {1'b0, x} + {1'b0, yy} + (m ? 1 : 0);
    it.exp_c = sum[W];
    if (!m) it.exp_v = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
    else    it.exp_v = (x[W-1] != y[W-1]) && (sum[W-1] != x[W-1]);
    if (s)       it.exp_res = sum[W-1:0];
    else if (m)  it.exp_res = x & y;
    else         it.exp_res = x | y;
    it.tag = t;
    return it;
  endfunction

  task automatic drive(input logic [W-1:0] x, input logic [W-1:0] y,
                       input logic m, input logic s, input string t);
    @(negedge clk);
    a = x; b = y; mode = m; sel = s;
    q.push_back(model(x, y, m, s, t));
  endtask

  task automatic all_ops(input logic [W-1:0] x, input logic [W-1:0] y);
    drive(x, y, 1'b0, 1'b0, "R1");
    drive(x, y, 1'b1, 1'b0, "R2");
    drive(x, y, 1'b0, 1'b1, "R3");
    drive(x, y, 1'b1, 1'b1, "R4");
  endtask

  initial begin : monitor
    item_t it;
    wait (rst_n);
    forever begin
      @(posedge clk);
      if (q.size() != 0) begin
        it = q.pop_front();
        n_chk++;
        if (res !== it.exp_res) begin
          n_bad++;
          $display("FAIL %s result: got %h expected %h", it.tag, res, it.exp_res);
        end
        if (c_o !== it.exp_c) begin
          n_bad++;
          $display("FAIL R5/R7 (%s) carry: got %b expected %b", it.tag, c_o, it.exp_c);
        end
        if (v_o !== it.exp_v) begin
          n_bad++;
          $display("FAIL R6/R7 (%s) overflow: got %b expected %b", it.tag, v_o, it.exp_v);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic [W-1:0] ra, rb;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R8 idle state: zero inputs give zero outputs, no clocked history
    drive('0, '0, 1'b0, 1'b0, "R8");
    all_ops('0, '0);
    all_ops('1, '1);
    all_ops(32'h7FFF_FFFF, 32'h0000_0001);   // R6 positive overflow on add
    all_ops(32'h8000_0000, 32'h0000_0001);   // R6 negative overflow on sub
    all_ops(32'h8000_0000, 32'h8000_0000);   // R5 carry, R6 add overflow
    all_ops(32'hFFFF_FFFF, 32'h0000_0001);   // R5 full ripple
    all_ops(32'h0000_0001, 32'hFFFF_FFFF);
    all_ops(32'h1234_5678, 32'h1234_5678);   // R4 A - A = 0
    all_ops(32'h0000_0000, 32'h8000_0000);   // sub of most negative
    all_ops(32'hA5A5_A5A5, 32'h5A5A_5A5A);
    // R7 flags with logic path selected
    drive(32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 1'b0, "R7");
    drive(32'h8000_0000, 32'h0000_0001, 1'b1, 1'b0, "R7");
    // R8 outputs follow inputs mid-cycle with no clock dependence
    drive(32'h0000_0003, 32'h0000_0005, 1'b0, 1'b1, "R8");
    drive(32'h0000_0003, 32'h0000_0005, 1'b1, 1'b1, "R8");
    for (int k = 0; k < 200; k++) begin
      ra = $urandom; rb = $urandom;
      all_ops(ra, rb);
    end
    @(negedge clk);
    wait (q.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule